// File: doc/BRIEF.md
# Programmable Pin-to-Function Mapper

This block links eight physical port pins to a set of internal control bits and status indicators. Each pin has its own 6-bit configuration word. The word sets whether the pin drives out or samples in, and which function number the pin is tied to. A pin set as an output shows its chosen indicator at once, through combinational logic. A pin set as an input writes its level into its chosen control bit on every rising edge of the host strobe clock.

The host writes the configuration words over a simple register write port. Pin 0 sits at address 0Fh, and each following pin sits at the next address. Any number of output pins may show the same indicator. Only one input pin should drive a given control bit. When two or more input pins claim the same bit, the lowest-numbered pin takes it and a conflict flag is raised.

Top module: `pinmap_top`

## Requirements
- R1: While reset is active and after it ends, every configuration word reads 0 (input, function 0), pin_oe and pin_out are 0, all control bits are 0 and conflict_o is 0.
- R2: A write with cfg_addr equal to 0Fh+p (p = 0..7) stores cfg_wdata as pin p's word at the rising edge. cfg_rdata shows, combinationally, the word addressed by cfg_addr. Writes to other addresses change nothing, and other addresses read 0.
- R3: Word bit 5 is the direction (1 = output, 0 = input). pin_oe[p] equals bit 5 of pin p's word.
- R4: An output pin whose function code s (bits 4:0) lies in 1..NUM_FUNC-1 drives ind_i[s]. It follows changes in ind_i in the same cycle, with no clock edge needed.
- R5: Several output pins that select the same code all show the same indicator value.
- R6: pin_out[p] is 0 when pin p is an input, or when it is an output whose code is 0 or at least NUM_FUNC.
- R7: An input pin whose code s lies in 1..NUM_FUNC-1 loads its pin_in level into ctrl_q[s] at the next rising clock edge, and keeps doing so on every edge.
- R8: A control bit that no input pin selects keeps its value. This includes bits selected only by output pins, and bit 0, which stays 0.
- R9: When two or more input pins select the same valid code, the lowest-numbered of them sets the bit, and conflict_o is high for as long as the overlap exists.
- R10: Input pins with code 0, or with a code of at least NUM_FUNC, touch no control bit and never raise conflict_o, even when several of them share that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host strobe clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 6 | Configuration word to write |
| cfg_rdata | output | 6 | Word at cfg_addr, 0 outside the pin range |
| ind_i | input | NUM_FUNC (24) | Status indicators, indexed by function code |
| pin_in | input | 8 | Levels sampled from the port pins |
| pin_out | output | 8 | Levels driven to the port pins |
| pin_oe | output | 8 | Per-pin output enable |
| ctrl_q | output | NUM_FUNC (24) | Control bits, indexed by function code |
| conflict_o | output | 1 | Two or more input pins share a valid code |

## Verification
The assertions assume that cfg_we, cfg_addr, cfg_wdata and pin_in are stable around the rising clock edge. They also assume that reset is applied once at start-up, before any of these inputs carry meaning. The bench changes every input only on the falling edge and holds it for at least a full cycle. Expected control bits come from a shadow of the configuration that the bench writes itself, so they stay valid even while configuration words are rewritten one by one. This matters because capture continues during those writes.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;
  localparam int SEL_W = 5;
  localparam int CFG_W = SEL_W + 1;

  typedef struct packed {
    logic                 drive_out;
    logic [SEL_W-1:0]     fsel;
  } pin_cfg_t;

  // A code is live when it names a real function (code 0 means none).
  function automatic logic fsel_live(input logic [SEL_W-1:0] s, input int nfunc);
    return (s != '0) && (int'(s) < nfunc);
  endfunction

  // True when more than one bit of a claim vector is set.
  function automatic logic multi_claim(input logic [7:0] v);
    return (v & (v - 8'd1)) != 8'd0;
  endfunction
endpackage

// File: rtl/pinmap_cfg_bank.sv
module pinmap_cfg_bank
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS  = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [CFG_W-1:0]          cfg_wdata,
  output logic [CFG_W-1:0]          cfg_rdata,
  output pin_cfg_t [NUM_PINS-1:0]   cfg_q
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [NUM_PINS-1:0] wsel;

  assign off      = cfg_addr - BASE_ADDR;
  assign in_range = (cfg_addr >= BASE_ADDR) && (off < ADDR_W'(NUM_PINS));
  assign idx      = off[IDX_W-1:0];

  always_comb begin
    wsel = '0;
    if (cfg_we && in_range) wsel[idx] = 1'b1;
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q[p] <= '0;
        else if (wsel[p]) cfg_q[p] <= pin_cfg_t'(cfg_wdata);
      end

      assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel[p] |=> $stable(cfg_q[p]));
    end
  endgenerate

  assign cfg_rdata = in_range ? CFG_W'(cfg_q[idx]) : '0;

  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
endmodule

// File: rtl/pinmap_out_mux.sv
module pinmap_out_mux
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_FUNC = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pin_cfg_t [NUM_PINS-1:0] cfg_q,
  input  logic [NUM_FUNC-1:0]     ind_i,
  output logic [NUM_PINS-1:0]     pin_out,
  output logic [NUM_PINS-1:0]     pin_oe
);
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pin_oe[p]  = cfg_q[p].drive_out;
      pin_out[p] = 1'b0;
      if (cfg_q[p].drive_out && fsel_live(cfg_q[p].fsel, NUM_FUNC))
        pin_out[p] = ind_i[cfg_q[p].fsel];
    end
  end

  assert_quiet_inputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/pinmap_in_capture.sv
module pinmap_in_capture
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_FUNC = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pin_cfg_t [NUM_PINS-1:0] cfg_q,
  input  logic [NUM_PINS-1:0]     pin_in,
  output logic [NUM_FUNC-1:0]     ctrl_q,
  output logic                    conflict_o
);
  // claim[f][p]: input pin p selects function f.
  logic [NUM_PINS-1:0] claim [NUM_FUNC];
  logic [NUM_FUNC-1:0] claimed;
  logic [NUM_FUNC-1:0] clash;
  logic [NUM_FUNC-1:0] win_val;

  always_comb begin
    for (int f = 0; f < NUM_FUNC; f++) begin
      claim[f]   = '0;
      win_val[f] = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
        claim[f][p] = (f != 0) && !cfg_q[p].drive_out && (cfg_q[p].fsel == SEL_W'(f));
      // Walk from the top so the lowest-numbered claimant is left standing.
      for (int p = NUM_PINS - 1; p >= 0; p--)
        if (claim[f][p]) win_val[f] = pin_in[p];
      claimed[f] = |claim[f];
      clash[f]   = multi_claim(8'(claim[f]));
    end
  end

  assign conflict_o = |clash;

  generate
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ctrl_q[f] <= 1'b0;
        else if (claimed[f]) ctrl_q[f] <= win_val[f];
      end

      assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !claimed[f] |=> $stable(ctrl_q[f]));

      assert_single_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict_o |-> $onehot0(claim[f]));
    end
  endgenerate
endmodule

// File: rtl/pinmap_top.sv
module pinmap_top
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_FUNC = 24,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic [NUM_FUNC-1:0] ind_i,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_FUNC-1:0] ctrl_q,
  output logic                conflict_o
);
  pin_cfg_t [NUM_PINS-1:0] cfg_q;

  pinmap_cfg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_q(cfg_q));

  pinmap_out_mux #(.NUM_PINS(NUM_PINS), .NUM_FUNC(NUM_FUNC)) u_out (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .ind_i(ind_i),
    .pin_out(pin_out), .pin_oe(pin_oe));

  pinmap_in_capture #(.NUM_PINS(NUM_PINS), .NUM_FUNC(NUM_FUNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .pin_in(pin_in),
    .ctrl_q(ctrl_q), .conflict_o(conflict_o));

  assert_bit0_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] == 1'b0);
endmodule

// File: tb/sim_pinmap_top.sv
module sim_pinmap_top;
  localparam int NF = 24;
  localparam logic [7:0] BASE = 8'h0F;
  localparam int NV = 5;

  // Per-vector configuration {pin7..pin0}, indicators, pin levels, expectations.
  localparam logic [47:0] T_CFG [NV] = '{
    {8{6'h23}},
    {6'h00, 6'h07, 6'h06, 6'h04, 6'h3E, 6'h25, 6'h22, 6'h21},
    {6'h00, 6'h00, 6'h09, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00},
    {6'h00, 6'h00, 6'h09, 6'h00, 6'h00, 6'h09, 6'h00, 6'h00},
    {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h19, 6'h19}};
  localparam logic [NF-1:0] T_IND [NV] = '{24'h000008, 24'h000026, 24'h0, 24'hFFFFFF, 24'h0};
  localparam logic [7:0] T_PIN [NV] = '{8'h00, 8'hFF, 8'h20, 8'h20, 8'hFF};
  localparam logic [7:0] T_OUT [NV] = '{8'hFF, 8'h07, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] T_OE  [NV] = '{8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00};
  localparam logic       T_CNF [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic [NF-1:0] ind_i = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic [NF-1:0] ctrl_q;
  logic conflict_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0][5:0] mcfg;
  logic [NF-1:0] exp_ctrl;

  always #10 clk = ~clk;

  pinmap_top u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ind_i(ind_i), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_q(ctrl_q), .conflict_o(conflict_o));

  // Reference: later (lower) pins overwrite, so the lowest claimant is kept.
  function automatic logic [NF-1:0] model(input logic [7:0][5:0] c, input logic [7:0] lv,
                                          input logic [NF-1:0] prev);
    logic [NF-1:0] r = prev;
    for (int p = 7; p >= 0; p--)
      if (!c[p][5] && c[p][4:0] != 5'd0 && int'(c[p][4:0]) < NF) r[c[p][4:0]] = lv[p];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcfg <= '0;
      exp_ctrl <= '0;
    end else begin
      exp_ctrl <= model(mcfg, pin_in, exp_ctrl);
      if (cfg_we && cfg_addr >= BASE && cfg_addr < BASE + 8'd8)
        mcfg[3'(cfg_addr - BASE)] <= cfg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: state held during and after reset
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", 32'(pin_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", 32'(ctrl_q), 32'h0);
    chk("R1 out", 32'(pin_out), 32'h0);
    chk("R1 conflict", 32'(conflict_o), 32'h0);
    for (int p = 0; p < 8; p++) begin
      cfg_addr = BASE + 8'(p); #1;
      chk("R1 cfg word", 32'(cfg_rdata), 32'h0);
    end

    // Vector table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < 8; p++) wr(BASE + 8'(p), T_CFG[v][p*6 +: 6]);
      ind_i = T_IND[v]; pin_in = T_PIN[v];
      #2;
      chk("R3 pin_oe", 32'(pin_oe), 32'(T_OE[v]));
      chk("R4/R5/R6 pin_out", 32'(pin_out), 32'(T_OUT[v]));
      chk("R9/R10 conflict", 32'(conflict_o), 32'(T_CNF[v]));
      @(negedge clk);
      chk("R7/R8 ctrl", 32'(ctrl_q), 32'(exp_ctrl));
      if (v == 2) chk("R7 pin5 sets bit9", 32'(ctrl_q[9]), 32'h1);
      if (v == 3) chk("R9 lowest pin wins", 32'(ctrl_q[9]), 32'h0);
      if (v == 1) begin
        chk("R8 output-selected bit1 kept", 32'(ctrl_q[1]), 32'h0);
        ind_i = 24'h0; #1;
        chk("R4 follows indicator without edge", 32'(pin_out), 32'h0);
      end
    end

    // R2: readback and ignored out-of-range writes
    wr(8'h0E, 6'h3F);
    wr(8'h17, 6'h3F);
    cfg_addr = 8'h0E; #1; chk("R2 below range reads 0", 32'(cfg_rdata), 32'h0);
    cfg_addr = 8'h17; #1; chk("R2 above range reads 0", 32'(cfg_rdata), 32'h0);
    wr(8'h12, 6'h2A);
    for (int p = 0; p < 8; p++) begin
      cfg_addr = BASE + 8'(p); #1;
      chk("R2 readback", 32'(cfg_rdata), 32'(mcfg[p]));
    end
    cfg_addr = 8'h12; #1; chk("R2 pin3 word", 32'(cfg_rdata), 32'h2A);
    chk("R3 pin3 output", 32'(pin_oe), 32'h08);

    // R8: bit 0 stays clear with code-0 inputs driven high
    @(negedge clk);
    chk("R8 bit0", 32'(ctrl_q[0]), 32'h0);
    finish_run();
  end
endmodule